// File: doc/BRIEF.md
# Register File with Stack Engine

This block holds the programmer-visible registers of a small 16-bit CPU datapath: four general registers, a stack pointer and a program counter. It carries out one command at a time from a command port. These commands are register moves, the transfers between the first general register and the stack pointer or program counter, stack pushes and pops, and loads and stores that use the third or fourth general register as a memory index. The instruction decoder, the ALU and the bus arbiter are outside this block.

Memory is byte addressed and little-endian. The block places a one-cycle request on a synchronous memory interface in the cycle it accepts a memory command. Writes complete in that cycle. A read holds the block busy until the read-valid strobe returns, and the destination is written in that cycle. The stack grows downward. A push lowers the pointer before it writes, and a pop reads at the pointer and then raises it. The step is 2 for a register and 1 for the 8-bit status value. The status register is not held here. Its value arrives on the command port for a push, and a popped value is handed back on a dedicated output.

Top module: `rsc_regstack_core`

## Requirements
- R1: After reset, all four general registers read 0, `sp_out` equals parameter SP_RST, `pc_out` equals parameter PC_RST, and `ready` is 1.
- R2: Opcode 1 (move) copies general register `cmd_src` into `cmd_dst` when they differ. With `cmd_src` equal to `cmd_dst` the command changes no register.
- R3: Opcode 2 copies R0 into SP. Opcode 3 copies SP into R0. No other command moves a value between SP and a general register.
- R4: Opcode 4 loads PC from R0. Opcode 5 writes the current PC as a 2-byte value at SP-2, sets SP to SP-2 and loads PC from R0. No other command changes PC.
- R5: Opcode 6 writes general register `cmd_src` as 2 bytes at SP-2 and sets SP to SP-2. Opcode 7 writes `cmd_ps` as 1 byte at SP-1 (`mem_wdata[7:0]`, upper byte 0) and sets SP to SP-1.
- R6: Opcode 8 reads 2 bytes at SP, sets SP to SP+2 and writes the returned data into `cmd_dst`. Opcode 9 reads 1 byte at SP and sets SP to SP+1. In the cycle the read returns, it raises `ps_pop_valid` with `ps_pop_data` = `mem_rdata[7:0]`.
- R7: Opcode 10 (load) and opcode 11 (store) address memory at R2 (`cmd_idx`=0) or R3 (`cmd_idx`=1). `cmd_byte`=0 moves 2 bytes and `cmd_byte`=1 moves 1 byte. A byte load zero-extends `mem_rdata[7:0]`, and a byte store drives the low byte of the source on `mem_wdata[7:0]` with the upper byte 0. With `cmd_postinc`=1 the index register advances by the transfer size. A store sends the index value from before the increment. When a load's destination is its own index register, the loaded data wins.
- R8: `ready` is 1 while no read is pending. A read command drops `ready` until `mem_rvalid` returns, and commands offered while `ready` is 0 are ignored. `mem_rvalid` has no effect while no read is pending.
- R9: `mem_req` is 1 for exactly the accepting cycle of a memory command (opcodes 5 to 11). `mem_we` is 1 with it for opcodes 5, 6, 7 and 11. `mem_two_bytes` is 1 for 16-bit transfers.
- R10: Stack and index arithmetic wraps modulo 2^16. A 2-byte push at SP=0 writes at 0xFFFE.
- R11: Opcode 0 and opcodes 12 to 15 change no register and make no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 4 | Opcode |
| cmd_src | input | 2 | Source general register |
| cmd_dst | input | 2 | Destination general register |
| cmd_idx | input | 1 | Index register select: 0 = R2, 1 = R3 |
| cmd_byte | input | 1 | Load/store width: 1 = byte, 0 = 16-bit |
| cmd_postinc | input | 1 | Advance the index register after access |
| cmd_ps | input | 8 | Status value for a status push |
| ready | output | 1 | Block can accept a command |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_two_bytes | output | 1 | Transfer is 16 bits (else 8) |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data, little-endian |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 16 | Read data |
| ps_pop_valid | output | 1 | Popped status byte valid |
| ps_pop_data | output | 8 | Popped status byte |
| rd_sel | input | 2 | General register read select |
| rd_data | output | 16 | Selected general register |
| sp_out | output | 16 | Stack pointer |
| pc_out | output | 16 | Program counter |

## Verification
A wrong stack pointer shows on the next stack command. It appears as a wrong `mem_addr` in that command's accepting cycle and as a wrong `sp_out` one cycle later. A wrong pending-read destination or width shows on `rd_data` in the cycle after `mem_rvalid`. A stuck busy state shows as `ready` staying low, and a missing busy state shows as `mem_req` firing on a command offered during a pending read. The bench compares every register and the full request against a model after each command, so a fault is seen within one command.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int GPR_COUNT = 4;
    localparam int GPR_SEL_W = $clog2(GPR_COUNT);
    localparam int STATUS_W  = 8;
    localparam int BYTE_W    = 8;
    localparam int OP_W      = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP      = 4'd0,
        OP_MOV      = 4'd1,
        OP_SP_LOAD  = 4'd2,
        OP_SP_READ  = 4'd3,
        OP_JUMP     = 4'd4,
        OP_CALL     = 4'd5,
        OP_PUSH     = 4'd6,
        OP_PUSH_ST  = 4'd7,
        OP_POP      = 4'd8,
        OP_POP_ST   = 4'd9,
        OP_LOAD     = 4'd10,
        OP_STORE    = 4'd11
    } rsc_op_e;

    typedef enum logic [1:0] {
        LDK_WORD   = 2'd0,
        LDK_BYTE   = 2'd1,
        LDK_STATUS = 2'd2
    } rsc_ldkind_e;

    typedef enum logic [1:0] {
        WSRC_GPR    = 2'd0,
        WSRC_PC     = 2'd1,
        WSRC_STATUS = 2'd2
    } rsc_wsrc_e;

    typedef struct packed {
        logic        mov;
        logic        sp_from_r0;
        logic        r0_from_sp;
        logic        pc_from_r0;
        logic        mem_access;
        logic        mem_write;
        logic        wide;
        logic        via_sp;
        logic        sp_down;
        logic        via_idx;
        rsc_ldkind_e ldkind;
        rsc_wsrc_e   wsrc;
    } rsc_ctl_t;

endpackage

// File: rtl/rsc_decode.sv
module rsc_decode
    import rsc_pkg::*;
(
    input  logic [OP_W-1:0] op_raw,
    input  logic            byte_mode,
    output rsc_ctl_t        ctl
);

    always_comb begin
        ctl        = '0;
        ctl.wide   = 1'b1;
        ctl.ldkind = LDK_WORD;
        ctl.wsrc   = WSRC_GPR;
        case (rsc_op_e'(op_raw))
            OP_MOV:     ctl.mov = 1'b1;
            OP_SP_LOAD: ctl.sp_from_r0 = 1'b1;
            OP_SP_READ: ctl.r0_from_sp = 1'b1;
            OP_JUMP:    ctl.pc_from_r0 = 1'b1;
            OP_CALL: begin
                ctl.pc_from_r0 = 1'b1;
                ctl.mem_access = 1'b1;
                ctl.mem_write  = 1'b1;
                ctl.via_sp     = 1'b1;
                ctl.sp_down    = 1'b1;
                ctl.wsrc       = WSRC_PC;
            end
            OP_PUSH: begin
                ctl.mem_access = 1'b1;
                ctl.mem_write  = 1'b1;
                ctl.via_sp     = 1'b1;
                ctl.sp_down    = 1'b1;
            end
            OP_PUSH_ST: begin
                ctl.mem_access = 1'b1;
                ctl.mem_write  = 1'b1;
                ctl.via_sp     = 1'b1;
                ctl.sp_down    = 1'b1;
                ctl.wide       = 1'b0;
                ctl.wsrc       = WSRC_STATUS;
            end
            OP_POP: begin
                ctl.mem_access = 1'b1;
                ctl.via_sp     = 1'b1;
            end
            OP_POP_ST: begin
                ctl.mem_access = 1'b1;
                ctl.via_sp     = 1'b1;
                ctl.wide       = 1'b0;
                ctl.ldkind     = LDK_STATUS;
            end
            OP_LOAD: begin
                ctl.mem_access = 1'b1;
                ctl.via_idx    = 1'b1;
                ctl.wide       = ~byte_mode;
                ctl.ldkind     = byte_mode ? LDK_BYTE : LDK_WORD;
            end
            OP_STORE: begin
                ctl.mem_access = 1'b1;
                ctl.mem_write  = 1'b1;
                ctl.via_idx    = 1'b1;
                ctl.wide       = ~byte_mode;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rsc_stepper.sv
module rsc_stepper #(
    parameter int W = 16
) (
    input  logic [W-1:0] base,
    input  logic         wide,
    input  logic         down,
    output logic [W-1:0] result
);

    localparam logic [W-1:0] STEP_NARROW = W'(1);
    localparam logic [W-1:0] STEP_WIDE   = W'(2);

    logic [W-1:0] step;

    always_comb begin
        step   = wide ? STEP_WIDE : STEP_NARROW;
        result = down ? (base - step) : (base + step);
    end

endmodule

// File: rtl/rsc_seq.sv
module rsc_seq
    import rsc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_read,
    input  logic [GPR_SEL_W-1:0] start_dst,
    input  rsc_ldkind_e          start_kind,
    input  logic                 rvalid,
    output logic                 ready,
    output logic                 resp_fire,
    output logic [GPR_SEL_W-1:0] pend_dst,
    output rsc_ldkind_e          pend_kind
);

    typedef struct packed {
        logic                 busy;
        logic [GPR_SEL_W-1:0] dst;
        rsc_ldkind_e          kind;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!seq_q.busy) begin
            if (start_read) begin
                seq_d.busy = 1'b1;
                seq_d.dst  = start_dst;
                seq_d.kind = start_kind;
            end
        end else if (rvalid) begin
            seq_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.busy <= 1'b0;
            seq_q.dst  <= '0;
            seq_q.kind <= LDK_WORD;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready     = ~seq_q.busy;
    assign resp_fire = seq_q.busy & rvalid;
    assign pend_dst  = seq_q.dst;
    assign pend_kind = seq_q.kind;

endmodule

// File: rtl/rsc_regstack_core.sv
module rsc_regstack_core
    import rsc_pkg::*;
#(
    parameter int              DATA_W = 16,
    parameter logic [DATA_W-1:0] PC_RST = '0,
    parameter logic [DATA_W-1:0] SP_RST = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [OP_W-1:0]      cmd_op,
    input  logic [GPR_SEL_W-1:0] cmd_src,
    input  logic [GPR_SEL_W-1:0] cmd_dst,
    input  logic                 cmd_idx,
    input  logic                 cmd_byte,
    input  logic                 cmd_postinc,
    input  logic [STATUS_W-1:0]  cmd_ps,
    output logic                 ready,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic                 mem_two_bytes,
    output logic [DATA_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic                 mem_rvalid,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 ps_pop_valid,
    output logic [STATUS_W-1:0]  ps_pop_data,
    input  logic [GPR_SEL_W-1:0] rd_sel,
    output logic [DATA_W-1:0]    rd_data,
    output logic [DATA_W-1:0]    sp_out,
    output logic [DATA_W-1:0]    pc_out
);

    localparam int HI_PAD_W  = DATA_W - BYTE_W;
    localparam int ST_PAD_W  = DATA_W - STATUS_W;
    localparam logic [GPR_SEL_W-1:0] IDX_BASE = GPR_SEL_W'(2);

    typedef struct packed {
        logic [GPR_COUNT-1:0][DATA_W-1:0] gpr;
        logic [DATA_W-1:0]                sp;
        logic [DATA_W-1:0]                pc;
    } arch_t;

    arch_t arch_d, arch_q;

    rsc_ctl_t             ctl;
    logic                 accept;
    logic [GPR_SEL_W-1:0] idx_sel;
    logic [DATA_W-1:0]    idx_val;
    logic [DATA_W-1:0]    idx_step;
    logic [DATA_W-1:0]    sp_step;
    logic [DATA_W-1:0]    src_val;
    logic                 start_read;
    logic                 resp_fire;
    logic [GPR_SEL_W-1:0] pend_dst;
    rsc_ldkind_e          pend_kind;

    rsc_decode u_decode (
        .op_raw    (cmd_op),
        .byte_mode (cmd_byte),
        .ctl       (ctl)
    );

    rsc_stepper #(.W(DATA_W)) u_sp_step (
        .base   (arch_q.sp),
        .wide   (ctl.wide),
        .down   (ctl.sp_down),
        .result (sp_step)
    );

    rsc_stepper #(.W(DATA_W)) u_idx_step (
        .base   (idx_val),
        .wide   (ctl.wide),
        .down   (1'b0),
        .result (idx_step)
    );

    rsc_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_read (start_read),
        .start_dst  (cmd_dst),
        .start_kind (ctl.ldkind),
        .rvalid     (mem_rvalid),
        .ready      (ready),
        .resp_fire  (resp_fire),
        .pend_dst   (pend_dst),
        .pend_kind  (pend_kind)
    );

    // Command-side operand selection and memory request
    always_comb begin
        accept     = cmd_valid & ready;
        idx_sel    = IDX_BASE | GPR_SEL_W'(cmd_idx);
        idx_val    = arch_q.gpr[idx_sel];
        src_val    = arch_q.gpr[cmd_src];
        start_read = accept & ctl.mem_access & ~ctl.mem_write;

        mem_req       = accept & ctl.mem_access;
        mem_we        = accept & ctl.mem_access & ctl.mem_write;
        mem_two_bytes = ctl.wide;

        if (ctl.via_sp) begin
            mem_addr = ctl.sp_down ? sp_step : arch_q.sp;
        end else begin
            mem_addr = idx_val;
        end

        case (ctl.wsrc)
            WSRC_PC:     mem_wdata = arch_q.pc;
            WSRC_STATUS: mem_wdata = {{ST_PAD_W{1'b0}}, cmd_ps};
            default:     mem_wdata = ctl.wide ? src_val
                                              : {{HI_PAD_W{1'b0}}, src_val[BYTE_W-1:0]};
        endcase
    end

    // Next architectural state
    always_comb begin
        arch_d = arch_q;
        if (accept) begin
            if (ctl.mov && (cmd_src != cmd_dst)) begin
                arch_d.gpr[cmd_dst] = src_val;
            end
            if (ctl.sp_from_r0) begin
                arch_d.sp = arch_q.gpr[0];
            end
            if (ctl.r0_from_sp) begin
                arch_d.gpr[0] = arch_q.sp;
            end
            if (ctl.pc_from_r0) begin
                arch_d.pc = arch_q.gpr[0];
            end
            if (ctl.via_sp) begin
                arch_d.sp = sp_step;
            end
            if (ctl.via_idx && cmd_postinc) begin
                arch_d.gpr[idx_sel] = idx_step;
            end
        end
        if (resp_fire) begin
            case (pend_kind)
                LDK_WORD: arch_d.gpr[pend_dst] = mem_rdata;
                LDK_BYTE: arch_d.gpr[pend_dst] = {{HI_PAD_W{1'b0}}, mem_rdata[BYTE_W-1:0]};
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arch_q.gpr <= '0;
            arch_q.sp  <= SP_RST;
            arch_q.pc  <= PC_RST;
        end else begin
            arch_q <= arch_d;
        end
    end

    assign ps_pop_valid = resp_fire & (pend_kind == LDK_STATUS);
    assign ps_pop_data  = mem_rdata[STATUS_W-1:0];
    assign rd_data      = arch_q.gpr[rd_sel];
    assign sp_out       = arch_q.sp;
    assign pc_out       = arch_q.pc;

endmodule

// File: rtl/rsc_checker.sv
module rsc_checker
    import rsc_pkg::*;
#(
    parameter int W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [OP_W-1:0] cmd_op,
    input logic            ready,
    input logic            mem_req,
    input logic            mem_we,
    input logic [W-1:0]    mem_addr,
    input logic [W-1:0]    sp,
    input logic [W-1:0]    pc
);

    localparam logic [W-1:0] TWO = W'(2);

    logic take;
    assign take = cmd_valid & ready;

    // R9: a request only appears on an accepted command
    p_req_on_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> take);

    // R8: a read request leaves the block busy in the following cycle
    p_read_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !ready);

    // R8: no request while busy
    p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !mem_req);

    // R5: word push address is the pre-decremented pointer
    p_push_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == OP_PUSH) |-> (mem_addr == sp - TWO));

    // R5: word push lowers the pointer by two
    p_push_sp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == OP_PUSH) |=> (sp == $past(sp) - TWO));

    // R6: word pop reads at the pointer and raises it by two
    p_pop_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == OP_POP) |-> (mem_addr == sp));

    p_pop_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == OP_POP) |=> (sp == $past(sp) + TWO));

    // R4: only jump and call alter the program counter
    p_pc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && (cmd_op == OP_JUMP || cmd_op == OP_CALL)) |=> $stable(pc));

endmodule

bind rsc_regstack_core rsc_checker #(.W(DATA_W)) u_rsc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .ready     (ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .sp        (sp_out),
    .pc        (pc_out)
);

// File: tb/rsc_regstack_core_test.sv
`timescale 1ns/100ps
module rsc_regstack_core_test;

    localparam logic [15:0] T_PC_RST = 16'h0040;
    localparam logic [15:0] T_SP_RST = 16'h8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [1:0]  cmd_src = '0;
    logic [1:0]  cmd_dst = '0;
    logic        cmd_idx = 1'b0;
    logic        cmd_byte = 1'b0;
    logic        cmd_postinc = 1'b0;
    logic [7:0]  cmd_ps = '0;
    logic        ready;
    logic        mem_req, mem_we, mem_two_bytes;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        ps_pop_valid;
    logic [7:0]  ps_pop_data;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data, sp_out, pc_out;

    always #2.5 clk = ~clk;

    rsc_regstack_core #(.DATA_W(16), .PC_RST(T_PC_RST), .SP_RST(T_SP_RST)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_idx(cmd_idx), .cmd_byte(cmd_byte),
        .cmd_postinc(cmd_postinc), .cmd_ps(cmd_ps), .ready(ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_two_bytes(mem_two_bytes), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .ps_pop_valid(ps_pop_valid), .ps_pop_data(ps_pop_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .sp_out(sp_out), .pc_out(pc_out)
    );

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] m_gpr [4];
    logic [15:0] m_sp, m_pc;
    logic [7:0]  mem [logic [15:0]];

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        if (mem.exists(a)) return mem[a];
        return (a[7:0] * 8'd37 + a[15:8]) ^ 8'h5A;
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            1: return "R2";
            2, 3: return "R3";
            4, 5: return "R4";
            6, 7: return "R5";
            8, 9: return "R6";
            10, 11: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic verify_state(input string tag);
        for (int r = 0; r < 4; r++) begin
            rd_sel = 2'(r);
            #0.1;
            check(tag, $sformatf("gpr%0d", r), {16'h0, rd_data}, {16'h0, m_gpr[r]});
        end
        check(tag, "sp", {16'h0, sp_out}, {16'h0, m_sp});
        check(tag, "pc", {16'h0, pc_out}, {16'h0, m_pc});
    endtask

    task automatic run_cmd(input int op, input int src, input int dst, input int idx,
                           input bit byt, input bit pinc, input logic [7:0] ps,
                           input int delay, input bit poke);
        bit          ereq = 0, ewe = 0, etwo = 1, eread = 0;
        int          ek = 0;
        int          ix = 2 + idx;
        logic [15:0] ea = '0, ew = '0, rv;
        logic [15:0] srcv = m_gpr[src];
        string       tg = tag_of(op);
        case (op)
            1: if (src != dst) m_gpr[dst] = srcv;
            2: m_sp = m_gpr[0];
            3: m_gpr[0] = m_sp;
            4: m_pc = m_gpr[0];
            5: begin m_sp -= 16'd2; ereq = 1; ewe = 1; ea = m_sp; ew = m_pc; m_pc = m_gpr[0]; end
            6: begin m_sp -= 16'd2; ereq = 1; ewe = 1; ea = m_sp; ew = srcv; end
            7: begin m_sp -= 16'd1; ereq = 1; ewe = 1; etwo = 0; ea = m_sp; ew = {8'h0, ps}; end
            8: begin ereq = 1; eread = 1; ea = m_sp; m_sp += 16'd2; ek = 0; end
            9: begin ereq = 1; eread = 1; etwo = 0; ea = m_sp; m_sp += 16'd1; ek = 2; end
            10: begin
                ereq = 1; eread = 1; etwo = !byt; ea = m_gpr[ix]; ek = byt ? 1 : 0;
                if (pinc) m_gpr[ix] = m_gpr[ix] + (byt ? 16'd1 : 16'd2);
            end
            11: begin
                ereq = 1; ewe = 1; etwo = !byt; ea = m_gpr[ix];
                ew = byt ? {8'h0, srcv[7:0]} : srcv;
                if (pinc) m_gpr[ix] = m_gpr[ix] + (byt ? 16'd1 : 16'd2);
            end
            default: ;
        endcase

        @(negedge clk);
        cmd_valid = 1; cmd_op = 4'(op); cmd_src = 2'(src); cmd_dst = 2'(dst);
        cmd_idx = 1'(idx); cmd_byte = byt; cmd_postinc = pinc; cmd_ps = ps;
        #1;
        check("R8", "ready idle", {31'h0, ready}, 32'h1);
        check("R9", "mem_req", {31'h0, mem_req}, {31'h0, ereq});
        if (ereq) begin
            check("R9", "mem_we", {31'h0, mem_we}, {31'h0, ewe});
            check("R9", "mem_two_bytes", {31'h0, mem_two_bytes}, {31'h0, etwo});
            check(tg, "mem_addr", {16'h0, mem_addr}, {16'h0, ea});
            if (ewe) check(tg, "mem_wdata", {16'h0, mem_wdata}, {16'h0, ew});
        end
        @(posedge clk);
        if (ewe) begin
            mem[ea] = ew[7:0];
            if (etwo) mem[ea + 16'd1] = ew[15:8];
        end
        @(negedge clk);
        cmd_valid = 0;
        if (eread) begin
            #0.1;
            check("R8", "ready busy", {31'h0, ready}, 32'h0);
            for (int k = 0; k < delay; k++) begin
                if (poke) begin
                    cmd_valid = 1; cmd_op = 4'd11; cmd_src = 2'd0; cmd_idx = 1'b0;
                    #0.5;
                    check("R8", "req while busy", {31'h0, mem_req}, 32'h0);
                end
                @(negedge clk);
                cmd_valid = 0;
            end
            if (etwo) rv = {mem_rd(ea + 16'd1), mem_rd(ea)};
            else      rv = {8'hC3 ^ ea[7:0], mem_rd(ea)};
            mem_rvalid = 1; mem_rdata = rv;
            #0.5;
            check("R6", "ps_pop_valid", {31'h0, ps_pop_valid}, {31'h0, (ek == 2)});
            if (ek == 2) check("R6", "ps_pop_data", {24'h0, ps_pop_data}, {24'h0, rv[7:0]});
            @(negedge clk);
            mem_rvalid = 0;
            if (ek == 0) m_gpr[dst] = rv;
            else if (ek == 1) m_gpr[dst] = {8'h00, rv[7:0]};
        end
        verify_state(tg);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int r = 0; r < 4; r++) m_gpr[r] = '0;
        m_sp = T_SP_RST;
        m_pc = T_PC_RST;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1", "ready", {31'h0, ready}, 32'h1);
        verify_state("R1");

        // R3 then R10: SP from R0 (0), push wraps down
        run_cmd(2, 0, 0, 0, 0, 0, 8'h00, 0, 0);
        run_cmd(6, 1, 0, 0, 0, 0, 8'h00, 0, 0);
        check("R10", "sp wrap down", {16'h0, sp_out}, 32'h0000_FFFE);
        run_cmd(7, 0, 0, 0, 0, 0, 8'hA7, 0, 0);
        run_cmd(9, 0, 0, 0, 0, 0, 8'h00, 1, 1);
        run_cmd(8, 0, 3, 0, 0, 0, 8'h00, 2, 1);
        check("R10", "sp wrap up", {16'h0, sp_out}, 32'h0);
        // R7: load into own index register with postinc, loaded data wins
        run_cmd(10, 0, 2, 0, 0, 1, 8'h00, 0, 0);
        // R2: self move ignored
        run_cmd(1, 2, 1, 0, 0, 0, 8'h00, 0, 0);
        run_cmd(1, 1, 1, 0, 0, 0, 8'h00, 0, 0);
        // R8: stray read-valid while idle
        @(negedge clk);
        mem_rvalid = 1; mem_rdata = 16'hBEEF;
        #0.5;
        check("R8", "ps_pop_valid idle", {31'h0, ps_pop_valid}, 32'h0);
        @(negedge clk);
        mem_rvalid = 0;
        verify_state("R8");
        // R11: unknown opcode
        run_cmd(14, 1, 2, 1, 1, 1, 8'h11, 0, 0);
        run_cmd(0, 1, 2, 1, 1, 1, 8'h11, 0, 0);
        // R7: byte load through R3 with postinc, byte store
        run_cmd(8, 0, 3, 0, 0, 0, 8'h00, 0, 0);
        run_cmd(10, 0, 0, 1, 1, 1, 8'h00, 1, 0);
        run_cmd(11, 2, 0, 1, 1, 1, 8'h00, 0, 0);
        run_cmd(10, 0, 1, 1, 1, 0, 8'h00, 0, 0);
        // R4: jump and call
        run_cmd(4, 0, 0, 0, 0, 0, 8'h00, 0, 0);
        run_cmd(1, 2, 0, 0, 0, 0, 8'h00, 0, 0);
        run_cmd(5, 0, 0, 0, 0, 0, 8'h00, 0, 0);
        run_cmd(8, 0, 1, 0, 0, 0, 8'h00, 0, 0);
        run_cmd(3, 0, 0, 0, 0, 0, 8'h00, 0, 0);

        for (int n = 0; n < 400; n++) begin
            run_cmd($urandom_range(0, 15), $urandom_range(0, 3), $urandom_range(0, 3),
                    $urandom_range(0, 1), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    8'($urandom_range(0, 255)), $urandom_range(0, 2), 1'($urandom_range(0, 1)));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule